// File: doc/BRIEF.md
# Bayer Black Level Corrector

This block takes a raw colour-filter-array pixel stream, one pixel per cycle with start-of-frame and end-of-line markers, and removes the black pedestal that the sensor adds to every sample. Each of the four positions of the 2x2 mosaic has its own pedestal and its own gain. For each pixel the block subtracts the pedestal of the pixel's phase. It then handles a negative difference by clipping it to zero or by taking its magnitude. Next it multiplies the result by the phase gain, rounds it, and saturates it to the largest pixel code. A bypass setting passes pixels through untouched.

Settings are written through a small write-only register port into shadow copies. All of them move into the working set together on the first pixel of the next frame, so a frame is never processed with a mix of old and new values. The mosaic phase of a pixel comes from the parity of its row and column. A two-bit origin setting tells the block which phase the top-left pixel belongs to. A three-state tracker (`TRK_WAIT_SOF`, `TRK_IN_LINE`, `TRK_LINE_GAP`) follows the stream. From reset it waits in `TRK_WAIT_SOF` for the first marked frame start. From any state, an accepted pixel with the end-of-line marker leads to `TRK_LINE_GAP`. An accepted pixel without that marker leads to `TRK_IN_LINE`. A start-of-frame pixel resets both parities in whichever state it arrives.

Top module: `cfa_black_level`

## Requirements
- R1: The phase index of an accepted pixel is {row_parity XOR origin[1], col_parity XOR origin[0]}. Both parities are 0 on the start-of-frame pixel. The column parity toggles on every pixel and returns to 0 after an end-of-line pixel. The row parity toggles after each end-of-line pixel.
- R2: With bypass off and pixel >= pedestal, the output is floor(((pixel - pedestal) * gain + 2048) / 4096). The gain is unsigned with 4 integer and 12 fractional bits.
- R3: A result above 4095 is replaced by 4095.
- R4: With control bit 0 clear, a pixel below its pedestal gives 0.
- R5: With control bit 0 set, a pixel below its pedestal is processed using (pedestal - pixel) in place of the difference.
- R6: With control bit 1 set, the output pixel equals the input pixel.
- R7: The register map is as follows. Addresses 0 to 3 hold the pedestals of phases 0 to 3 (data bits 11:0). Addresses 4 to 7 hold the gains of phases 0 to 3 (data bits 15:0). Address 8 is control: bit 0 selects reflection, bit 1 selects bypass, and bits 3:2 hold the origin. A write to any other address changes nothing.
- R8: A written value is used from the next accepted start-of-frame pixel onward, including that pixel. A write in the same cycle as a start-of-frame pixel is used only from the following start-of-frame pixel.
- R9: Each accepted pixel appears on the output exactly two cycles later, with its start-of-frame and end-of-line markers. The output valid is high only in those cycles.
- R10: After reset, pixels arriving before the first start-of-frame pixel are discarded and produce no output.
- R11: After reset every pedestal is 0, every gain is 4096 (unity), and control is 0. While reset is held all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| pix_valid | input | 1 | Input pixel valid |
| pix_data | input | 12 | Input raw pixel |
| pix_sof | input | 1 | Input pixel is first of frame |
| pix_eol | input | 1 | Input pixel is last of line |
| cor_valid | output | 1 | Output pixel valid |
| cor_data | output | 12 | Corrected pixel |
| cor_sof | output | 1 | Output start-of-frame marker |
| cor_eol | output | 1 | Output end-of-line marker |

## Verification
A register write and the start-of-frame commit can fall in the same cycle. The bench provokes this by raising the write strobe on the very pixel that carries the frame-start marker. It then judges the outcome from the pixels: the frame just begun must still use the previous value, and only the frame after it may show the new one. Separately, a write in the middle of a frame must leave the rest of that frame untouched.

// File: rtl/cfa_blc_pkg.sv
package cfa_blc_pkg;

    typedef enum logic [1:0] {
        TRK_WAIT_SOF = 2'd0,
        TRK_IN_LINE  = 2'd1,
        TRK_LINE_GAP = 2'd2
    } trk_state_e;

    localparam int NUM_PHASES   = 4;
    localparam int ADDR_PED0    = 0;
    localparam int ADDR_GAIN0   = 4;
    localparam int ADDR_CTRL    = 8;
    localparam int CTRL_REFLECT = 0;
    localparam int CTRL_BYPASS  = 1;
    localparam int CTRL_ORG_LO  = 2;

endpackage

// File: rtl/cfa_blc_regs.sv
module cfa_blc_regs
    import cfa_blc_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 12,
    parameter int ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [COEF_W-1:0]              wr_data,
    input  logic                           commit,
    output logic [NUM_PHASES-1:0][PIX_W-1:0]  eff_ped,
    output logic [NUM_PHASES-1:0][COEF_W-1:0] eff_gain,
    output logic                           eff_reflect,
    output logic                           eff_bypass,
    output logic [1:0]                     eff_origin
);

    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

    logic [NUM_PHASES-1:0][PIX_W-1:0]  sh_ped,  act_ped;
    logic [NUM_PHASES-1:0][COEF_W-1:0] sh_gain, act_gain;
    logic [3:0] sh_ctrl, act_ctrl;

    genvar g;
    generate
        for (g = 0; g < NUM_PHASES; g++) begin : g_phase
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_ped[g]   <= '0;
                    sh_gain[g]  <= UNITY;
                    act_ped[g]  <= '0;
                    act_gain[g] <= UNITY;
                end else begin
                    if (commit) begin
                        act_ped[g]  <= sh_ped[g];
                        act_gain[g] <= sh_gain[g];
                    end
                    if (wr_en && wr_addr == ADDR_W'(ADDR_PED0 + g))
                        sh_ped[g] <= wr_data[PIX_W-1:0];
                    if (wr_en && wr_addr == ADDR_W'(ADDR_GAIN0 + g))
                        sh_gain[g] <= wr_data;
                end
            end
            assign eff_ped[g]  = commit ? sh_ped[g]  : act_ped[g];
            assign eff_gain[g] = commit ? sh_gain[g] : act_gain[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ctrl  <= '0;
            act_ctrl <= '0;
        end else begin
            if (commit)
                act_ctrl <= sh_ctrl;
            if (wr_en && wr_addr == ADDR_W'(ADDR_CTRL))
                sh_ctrl <= wr_data[3:0];
        end
    end

    logic [3:0] eff_ctrl;
    assign eff_ctrl    = commit ? sh_ctrl : act_ctrl;
    assign eff_reflect = eff_ctrl[CTRL_REFLECT];
    assign eff_bypass  = eff_ctrl[CTRL_BYPASS];
    assign eff_origin  = eff_ctrl[CTRL_ORG_LO +: 2];

    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R8: a commit moves the shadow set into the working set
    p_commit_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(commit) |-> (act_ctrl == $past(sh_ctrl)) && (act_ped == $past(sh_ped)));

    // R8: without a commit the working set holds still
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !$past(commit) |-> $stable(act_gain) && $stable(act_ctrl));

endmodule

// File: rtl/cfa_blc_tracker.sv
module cfa_blc_tracker
    import cfa_blc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eol,
    input  logic [1:0] origin,
    output logic       take,
    output logic       commit,
    output logic [1:0] phase
);

    trk_state_e state_q, state_d;
    logic row_q, col_q;
    logic row_cur, col_cur;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_WAIT_SOF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_WAIT_SOF: if (in_valid && in_sof)
                              state_d = in_eol ? TRK_LINE_GAP : TRK_IN_LINE;
            TRK_IN_LINE:  if (in_valid && in_eol)
                              state_d = TRK_LINE_GAP;
            TRK_LINE_GAP: if (in_valid)
                              state_d = in_eol ? TRK_LINE_GAP : TRK_IN_LINE;
            default:      state_d = TRK_WAIT_SOF;
        endcase
    end

    always_comb begin
        take    = 1'b0;
        row_cur = row_q;
        col_cur = col_q;
        unique case (state_q)
            TRK_WAIT_SOF: take = in_valid && in_sof;
            TRK_IN_LINE:  take = in_valid;
            TRK_LINE_GAP: begin
                take    = in_valid;
                col_cur = 1'b0;
            end
            default:      take = 1'b0;
        endcase
        if (in_sof) begin
            row_cur = 1'b0;
            col_cur = 1'b0;
        end
        commit = take && in_sof;
        phase  = {row_cur ^ origin[1], col_cur ^ origin[0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= 1'b0;
            col_q <= 1'b0;
        end else if (take) begin
            col_q <= in_eol ? 1'b0 : ~col_cur;
            row_q <= in_eol ? ~row_cur : row_cur;
        end
    end

    // R1: the frame's first pixel sits on the origin phase
    p_origin_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_sof |-> phase == origin);

    // R1: first pixel of a later line restarts the column parity
    p_col_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take && !in_sof && state_q == TRK_LINE_GAP |-> phase[0] == origin[0]);

    // R10: nothing is accepted until a frame has started
    p_wait_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == TRK_WAIT_SOF && in_valid && !in_sof |=> state_q == TRK_WAIT_SOF);

endmodule

// File: rtl/cfa_blc_datapath.sv
module cfa_blc_datapath
    import cfa_blc_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              take,
    input  logic [PIX_W-1:0]                  in_data,
    input  logic                              in_sof,
    input  logic                              in_eol,
    input  logic [1:0]                        phase,
    input  logic [NUM_PHASES-1:0][PIX_W-1:0]  ped,
    input  logic [NUM_PHASES-1:0][COEF_W-1:0] gain,
    input  logic                              reflect,
    input  logic                              bypass,
    output logic                              out_valid,
    output logic [PIX_W-1:0]                  out_data,
    output logic                              out_sof,
    output logic                              out_eol
);

    localparam int PROD_W = PIX_W + COEF_W + 1;
    localparam int Q_W    = PROD_W - FRAC_W;
    localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);
    localparam logic [PIX_W-1:0]  MAXV = '1;

    // stage 1: pedestal removal and negative handling
    logic [PIX_W-1:0] sel_ped;
    logic [PIX_W:0]   diff, ndiff;
    logic [PIX_W-1:0] mag;

    always_comb begin
        sel_ped = ped[phase];
        diff    = {1'b0, in_data} - {1'b0, sel_ped};
        ndiff   = -diff;
        if (!diff[PIX_W])  mag = diff[PIX_W-1:0];
        else if (reflect)  mag = ndiff[PIX_W-1:0];
        else               mag = '0;
    end

    logic              s1_valid, s1_sof, s1_eol, s1_bypass;
    logic [PIX_W-1:0]  s1_mag, s1_raw;
    logic [COEF_W-1:0] s1_gain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_sof    <= 1'b0;
            s1_eol    <= 1'b0;
            s1_bypass <= 1'b0;
            s1_mag    <= '0;
            s1_raw    <= '0;
            s1_gain   <= '0;
        end else begin
            s1_valid  <= take;
            s1_sof    <= take && in_sof;
            s1_eol    <= take && in_eol;
            s1_bypass <= bypass;
            s1_mag    <= mag;
            s1_raw    <= in_data;
            s1_gain   <= gain[phase];
        end
    end

    // stage 2: scale, round to nearest, saturate
    logic [PROD_W-1:0] prod;
    logic [Q_W-1:0]    quo;
    logic [PIX_W-1:0]  scaled;

    always_comb begin
        prod   = PROD_W'(s1_mag) * PROD_W'(s1_gain) + HALF;
        quo    = prod[PROD_W-1:FRAC_W];
        scaled = (quo > Q_W'(MAXV)) ? MAXV : quo[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            out_sof   <= s1_sof;
            out_eol   <= s1_eol;
            out_data  <= !s1_valid ? '0 : (s1_bypass ? s1_raw : scaled);
        end
    end

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)           warm_q <= '0;
        else if (warm_q != 2) warm_q <= warm_q + 2'd1;
    end

    // R9: two-cycle latency for every accepted pixel
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q == 2 |-> out_valid == $past(take, 2));

    // R9: frame marker travels with its pixel
    p_sof_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q == 2 |-> out_sof == $past(take && in_sof, 2));

    // R6: bypass reproduces the input pixel
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q == 2 && $past(take && bypass, 2) |-> out_data == $past(in_data, 2));

    // R4: at or below pedestal with clipping gives zero
    p_clip_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q == 2 && $past(take && !bypass && !reflect && (in_data <= sel_ped), 2)
        |-> out_data == '0);

endmodule

// File: rtl/cfa_black_level.sv
module cfa_black_level
    import cfa_blc_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 12,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [COEF_W-1:0] reg_wdata,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              pix_sof,
    input  logic              pix_eol,
    output logic              cor_valid,
    output logic [PIX_W-1:0]  cor_data,
    output logic              cor_sof,
    output logic              cor_eol
);

    logic take, commit;
    logic [1:0] phase, origin;
    logic reflect, bypass;
    logic [NUM_PHASES-1:0][PIX_W-1:0]  ped;
    logic [NUM_PHASES-1:0][COEF_W-1:0] gain;

    cfa_blc_regs #(
        .PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .commit(commit),
        .eff_ped(ped), .eff_gain(gain),
        .eff_reflect(reflect), .eff_bypass(bypass), .eff_origin(origin)
    );

    cfa_blc_tracker u_trk (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pix_valid), .in_sof(pix_sof), .in_eol(pix_eol),
        .origin(origin),
        .take(take), .commit(commit), .phase(phase)
    );

    cfa_blc_datapath #(
        .PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)
    ) u_dp (
        .clk(clk), .rst_n(rst_n),
        .take(take), .in_data(pix_data), .in_sof(pix_sof), .in_eol(pix_eol),
        .phase(phase), .ped(ped), .gain(gain),
        .reflect(reflect), .bypass(bypass),
        .out_valid(cor_valid), .out_data(cor_data),
        .out_sof(cor_sof), .out_eol(cor_eol)
    );

    // R11: outputs are quiet while reset is held
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> !cor_valid && cor_data == '0);

endmodule

// File: tb/test_cfa_black_level.sv
module test_cfa_black_level;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic pix_valid = 1'b0, pix_sof = 1'b0, pix_eol = 1'b0;
    logic [11:0] pix_data = '0;
    logic cor_valid, cor_sof, cor_eol;
    logic [11:0] cor_data;

    always #10 clk = ~clk;

    cfa_black_level i_cfa_black_level (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_sof(pix_sof), .pix_eol(pix_eol),
        .cor_valid(cor_valid), .cor_data(cor_data),
        .cor_sof(cor_sof), .cor_eol(cor_eol)
    );

    int n_checks = 0;
    int n_fails = 0;
    bit done = 0;

    // bench model of the register set
    int sh_ped[4], act_ped[4], sh_gain[4], act_gain[4];
    int sh_ctrl, act_ctrl;
    bit started;
    int brow, bcol;

    int   q_data[$];
    int   q_flags[$];
    string q_req[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int d, input int ph);
        int diff, p;
        if (act_ctrl[1]) return d;
        diff = d - act_ped[ph];
        if (diff < 0) diff = act_ctrl[0] ? -diff : 0;
        p = (diff * act_gain[ph] + 2048) >>> 12;
        return (p > 4095) ? 4095 : p;
    endfunction

    function automatic void model_write(input int a, input int w);
        if (a < 4)       sh_ped[a] = w & 12'hFFF;
        else if (a < 8)  sh_gain[a-4] = w & 16'hFFFF;
        else if (a == 8) sh_ctrl = w & 4'hF;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 0; pix_sof = 0; pix_eol = 0; reg_wr = 0;
        end
    endtask

    task automatic beat(input int d, input bit sof, input bit eol, input string req,
                        input bit wr, input int a, input int w);
        int ph;
        @(negedge clk);
        pix_valid = 1; pix_data = 12'(d); pix_sof = sof; pix_eol = eol;
        reg_wr = wr; reg_addr = 4'(a); reg_wdata = 16'(w);
        if (sof) begin
            act_ped = sh_ped; act_gain = sh_gain; act_ctrl = sh_ctrl;
            started = 1; brow = 0; bcol = 0;
        end
        if (started) begin
            ph = ((brow ^ act_ctrl[3]) << 1) | (bcol ^ act_ctrl[2]);
            q_data.push_back(model(d, ph));
            q_flags.push_back({30'd0, eol, sof});
            q_req.push_back(req);
            if (eol) begin brow ^= 1; bcol = 0; end
            else bcol ^= 1;
        end
        if (wr) model_write(a, w);
    endtask

    task automatic reg_write(input int a, input int w);
        @(negedge clk);
        pix_valid = 0; pix_sof = 0; pix_eol = 0;
        reg_wr = 1; reg_addr = 4'(a); reg_wdata = 16'(w);
        model_write(a, w);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic frame(input int rows, input int cols, input int seed, input string req);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < cols; c++)
                beat((seed + r * 37 + c * 211) % 4096, r == 0 && c == 0, c == cols - 1,
                     req, 0, 0, 0);
            if (r % 2 == 1) idle(1);
        end
    endtask

    task automatic drain(input string req);
        idle(4);
        check(q_data.size() == 0, req, q_data.size(), 0);
    endtask

    // output monitor: every output beat is compared with the model
    always @(negedge clk) begin
        if (rst_n && !done && cor_valid) begin
            if (q_data.size() == 0) begin
                check(0, "R9", 1, 0);
            end else begin
                int ed, ef;
                string rq;
                ed = q_data.pop_front(); ef = q_flags.pop_front(); rq = q_req.pop_front();
                check(cor_data == 12'(ed), rq, cor_data, ed);
                check({cor_eol, cor_sof} == 2'(ef), "R9", {cor_eol, cor_sof}, ef);
            end
        end
    end

    task automatic t_reset_state();
        @(negedge clk);
        check(!cor_valid && cor_data == 0 && !cor_sof && !cor_eol, "R11", cor_data, 0);
    endtask

    task automatic t_pre_sof_drop();
        // R10: these beats precede any frame start and must vanish
        for (int i = 0; i < 5; i++) beat(100 + i, 0, i == 4, "R10", 0, 0, 0);
        drain("R10");
    endtask

    task automatic t_defaults();
        frame(2, 6, 777, "R11");
        drain("R11");
    endtask

    task automatic t_phases();
        // R1 R2: distinct pedestal and gain per phase
        reg_write(0, 10);  reg_write(1, 200); reg_write(2, 300); reg_write(3, 400);
        reg_write(4, 'h1000); reg_write(5, 'h1800); reg_write(6, 'h2000); reg_write(7, 'h0C00);
        frame(4, 6, 900, "R1");
        drain("R1");
        reg_write(8, 4'b1100);
        frame(4, 5, 1500, "R1");
        drain("R1");
        reg_write(8, 4'b0100);
        frame(3, 3, 2500, "R2");
        drain("R2");
    endtask

    task automatic t_rounding();
        // R2: half-unit results round upward
        reg_write(8, 0);
        reg_write(0, 0); reg_write(4, 'h0800);
        beat(0, 0, 0, "R2", 0, 0, 0);
        idle(1);
        beat(1, 1, 0, "R2", 0, 0, 0); beat(9, 0, 0, "R2", 0, 0, 0);
        beat(3, 0, 0, "R2", 0, 0, 0); beat(4094, 0, 1, "R2", 0, 0, 0);
        drain("R2");
    endtask

    task automatic t_saturation();
        // R3: gain near 16 overflows for large pixels
        for (int k = 0; k < 4; k++) begin reg_write(k, 0); reg_write(4 + k, 'hFFFF); end
        beat(4095, 1, 0, "R3", 0, 0, 0); beat(300, 0, 0, "R3", 0, 0, 0);
        beat(1, 0, 0, "R3", 0, 0, 0);    beat(256, 0, 1, "R3", 0, 0, 0);
        drain("R3");
    endtask

    task automatic t_negative();
        for (int k = 0; k < 4; k++) begin reg_write(k, 500); reg_write(4 + k, 'h1000); end
        reg_write(8, 0);
        // R4: below pedestal clips
        beat(100, 1, 0, "R4", 0, 0, 0); beat(499, 0, 0, "R4", 0, 0, 0);
        beat(500, 0, 0, "R4", 0, 0, 0); beat(0, 0, 1, "R4", 0, 0, 0);
        drain("R4");
        reg_write(8, 1);
        reg_write(4, 'h2000);
        // R5: below pedestal reflects
        beat(100, 1, 0, "R5", 0, 0, 0); beat(499, 0, 0, "R5", 0, 0, 0);
        beat(0, 0, 0, "R5", 0, 0, 0);   beat(900, 0, 1, "R5", 0, 0, 0);
        drain("R5");
    endtask

    task automatic t_bypass();
        // R6: untouched pixels
        reg_write(8, 3);
        frame(2, 4, 3000, "R6");
        drain("R6");
        reg_write(8, 1);
    endtask

    task automatic t_bad_addr();
        // R7: unmapped addresses alter nothing
        reg_write(9, 'hFFFF); reg_write(12, 'h0002); reg_write(15, 'h1234);
        frame(2, 4, 1234, "R7");
        drain("R7");
    endtask

    task automatic t_shadow();
        // R8: mid-frame write waits for next frame
        reg_write(0, 0); reg_write(8, 0);
        beat(1000, 1, 0, "R8", 0, 0, 0);
        beat(1000, 0, 0, "R8", 1, 0, 800);
        beat(1000, 0, 0, "R8", 0, 0, 0);
        beat(1000, 0, 1, "R8", 0, 0, 0);
        beat(1000, 1, 0, "R8", 0, 0, 0);
        beat(1000, 0, 1, "R8", 0, 0, 0);
        drain("R8");
        // R8: write on the frame-start pixel waits one more frame
        beat(1000, 1, 0, "R8", 1, 0, 100);
        beat(1000, 0, 1, "R8", 0, 0, 0);
        beat(1000, 1, 0, "R8", 0, 0, 0);
        beat(1000, 0, 1, "R8", 0, 0, 0);
        drain("R8");
        check(act_ped[0] == 100, "R8", act_ped[0], 100);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            sh_ped[k] = 0; act_ped[k] = 0; sh_gain[k] = 4096; act_gain[k] = 4096;
        end
        sh_ctrl = 0; act_ctrl = 0; started = 0; brow = 0; bcol = 0;
        repeat (3) @(negedge clk);
        t_reset_state();
        @(negedge clk);
        rst_n = 1;
        t_pre_sof_drop();
        t_defaults();
        t_phases();
        t_rounding();
        t_saturation();
        t_negative();
        t_bypass();
        t_bad_addr();
        t_shadow();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule